// File: doc/BRIEF.md
# Single-Line Bus Ownership Handshake Controller

This block runs the host side of a bus-ownership exchange with external bus masters. Each requester has one shared, active-low line that carries three one-clock low pulses in turn. The requester pulses to ask for the bus. The host pulses back to hand the bus over, and then floats its own bus drivers. The requester pulses once more to return the bus. The number of lines is a parameter. The lowest-numbered line wins when several ask at the same time.

The host issues its grant pulse only at a legal bus-cycle boundary. That means the last state of the current cycle or the first state of the next one, as flagged by phase inputs from the bus-cycle engine. No grant is given while a locked instruction runs, during the first cycle of an interrupt acknowledge, or between the two halves of a word access split across an odd address. The open-drain line is modelled as a per-line drive-enable output and a per-line sampled input. The line reads high through a pull-up whenever nobody pulls it low.

Top module: `busown_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `rg_drive` bit is 0 and `bus_float` is 0.
- R2: A line sampled low at a rising edge while the host owns the bus marks that line as requesting. The grant is a single `rg_drive` bit for that line. It is high in the cycle after an edge at which the request is already marked and the grant conditions hold.
- R3: A grant starts only after an edge at which `phase_t4` or `phase_t1` is high. With both low, a marked request waits.
- R4: A grant starts only after an edge at which `lock_active`, `inta_first` and `split_word` are all low. A request that is held off this way stays marked and is granted once all three are low.
- R5: A grant pulse lasts exactly one clock, and at most one `rg_drive` bit is high in any cycle.
- R6: `bus_float` goes high in the cycle right after the grant pulse and stays high until the release.
- R7: While a master owns the bus, a low sample on that master's own line is its release, and `bus_float` is low from the next cycle on.
- R8: After a release there are at least two clocks in which neither `bus_float` nor any `rg_drive` bit is high, before the next grant pulse.
- R9: When line 0 and line 1 are both marked as requesting, line 0 is granted first.
- R10: A marked request that loses the priority choice stays marked, and it is granted after the current exchange has ended.
- R11: While a master owns the bus, low samples on any other line are ignored. They neither end the ownership nor mark a request.
- R12: The host drives a line low (`rg_drive` bit set) only in a grant pulse, never while `bus_float` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; lines and flags are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rg_in_n | input | NCH | Sampled level of each request/grant line (0 = pulled low) |
| phase_t4 | input | 1 | Bus cycle is in its last state |
| phase_t1 | input | 1 | Bus cycle is in its first state |
| lock_active | input | 1 | A locked instruction is executing |
| inta_first | input | 1 | First cycle of an interrupt acknowledge is running |
| split_word | input | 1 | Between the two halves of a split odd-address word access |
| rg_drive | output | NCH | Per-line enable to pull the line low (grant pulse) |
| bus_float | output | 1 | Host bus drivers are floated; a master owns the bus |

## Verification
The bench builds the block with its default of two lines. That is the smallest count at which the priority choice, a request held behind another master's exchange, and a pulse on a non-owner line during ownership can all happen. Directed sequences cover each blocking flag, the phase gate and the post-release gap with hand-computed timing. A long random phase then runs both lines' pulses against freely toggling phase and blocking flags, and compares the outputs every cycle with a requirement-level bench model.

// File: rtl/busown_pkg.sv
// Shared types for the bus ownership handshake controller.
package busown_pkg;
    // Who holds the local bus, plus the two one-clock transit states.
    typedef enum logic [1:0] {
        OWN_HOST   = 2'd0,  // host owns the bus, requests accepted
        OWN_GRANT  = 2'd1,  // grant pulse is on the line this cycle
        OWN_MASTER = 2'd2,  // an external master owns the bus
        OWN_GAP    = 2'd3   // dead cycle after a release
    } own_state_t;
endpackage

// File: rtl/rg_req_capture.sv
// Per-line request marks. A low sample taken while capture is enabled
// sets the mark, and a clear from the grant logic removes it. Clear wins
// when both hit the same line at the same edge.
// Assumes: line_low is already the sampled (active-high) view of the line.
module rg_req_capture #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture_en,
    input  logic [NCH-1:0] line_low,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] pend
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // Hold one request mark per line.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[c] <= 1'b0;
            else
                pend[c] <= (pend[c] | (capture_en & line_low[c])) & ~clr[c];
        end
    end
endmodule

// File: rtl/rg_boundary_gate.sv
// Decides whether the present clock is a legal point to hand over the bus.
// Assumes: phase and blocking flags are synchronous to clk.
module rg_boundary_gate (
    input  logic phase_t4,
    input  logic phase_t1,
    input  logic lock_active,
    input  logic inta_first,
    input  logic split_word,
    output logic gate_open
);
    logic at_edge;
    logic blocked;

    // A boundary is the last state of a cycle or the first of the next.
    always_comb at_edge = phase_t4 | phase_t1;

    // Any indivisible sequence in progress blocks the handover.
    always_comb blocked = lock_active | inta_first | split_word;

    // Open only on a boundary with nothing blocking.
    always_comb gate_open = at_edge & ~blocked;
endmodule

// File: rtl/rg_prio_pick.sv
// Fixed-priority choice among marked requests: the lowest index wins.
// Produces a one-hot vector and the matching index.
module rg_prio_pick #(
    parameter int NCH  = 2,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [NCH-1:0]  pick_oh,
    output logic [CH_W-1:0] pick_idx
);
    // Scan from the top down so the lowest set index is the last write.
    always_comb begin
        pick_oh  = '0;
        pick_idx = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (req[c]) begin
                pick_oh  = '0;
                pick_oh[c] = 1'b1;
                pick_idx = CH_W'(c);
            end
        end
    end

    // Some line is waiting.
    always_comb any = |req;
endmodule

// File: rtl/rg_own_fsm.sv
// Ownership sequencer: host -> grant pulse -> master owns -> gap -> host.
// Drives the per-line grant enable and the bus-float output from state.
// Assumes: pick_idx is valid whenever any_pend is high.
module rg_own_fsm
    import busown_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  line_low,
    input  logic            any_pend,
    input  logic            gate_open,
    input  logic [CH_W-1:0] pick_idx,
    output own_state_t      state,
    output logic            grant_fire,
    output logic [NCH-1:0]  rg_drive,
    output logic            bus_float
);
    own_state_t      state_nx;
    logic [CH_W-1:0] owner;
    logic            owner_rel;

    // Fire a grant when the host holds the bus, a line waits and the gate is open.
    always_comb grant_fire = (state == OWN_HOST) & any_pend & gate_open;

    // The current owner's line pulled low is its release.
    always_comb owner_rel = line_low[owner];

    // Next-state choice.
    always_comb begin
        state_nx = state;
        unique case (state)
            OWN_HOST:   if (grant_fire) state_nx = OWN_GRANT;
            OWN_GRANT:  state_nx = OWN_MASTER;
            OWN_MASTER: if (owner_rel) state_nx = OWN_GAP;
            OWN_GAP:    state_nx = OWN_HOST;
            default:    state_nx = OWN_HOST;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OWN_HOST;
        else        state <= state_nx;
    end

    // Remember which line was granted.
    always_ff @(posedge clk) begin
        if (!rst_n)          owner <= '0;
        else if (grant_fire) owner <= pick_idx;
    end

    // Grant pulse goes only to the owner's line.
    for (genvar c = 0; c < NCH; c++) begin : g_drv
        always_comb rg_drive[c] = (state == OWN_GRANT) && (owner == CH_W'(c));
    end

    // Host drivers float while a master owns the bus.
    always_comb bus_float = (state == OWN_MASTER);
endmodule

// File: rtl/busown_arbiter.sv
// Host-side bus ownership handshake controller for NCH single-wire
// request/grant lines. Each line carries request, grant and release as
// one-clock low pulses. The grant is given at a legal bus-cycle boundary,
// with fixed priority to the lowest line.
// Assumes: rg_in_n is the synchronous sampled level of each open-drain line,
// including the host's own pull-down during its grant pulse.
module busown_arbiter
    import busown_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] rg_in_n,
    input  logic           phase_t4,
    input  logic           phase_t1,
    input  logic           lock_active,
    input  logic           inta_first,
    input  logic           split_word,
    output logic [NCH-1:0] rg_drive,
    output logic           bus_float
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    own_state_t      state;
    logic [NCH-1:0]  line_low;
    logic [NCH-1:0]  pend;
    logic [NCH-1:0]  pick_oh;
    logic [NCH-1:0]  clr;
    logic [CH_W-1:0] pick_idx;
    logic            any_pend;
    logic            gate_open;
    logic            grant_fire;
    logic            capture_en;

    // Active-high view of each line.
    always_comb line_low = ~rg_in_n;

    // Requests are heard only while no master holds the bus.
    always_comb capture_en = (state == OWN_HOST) | (state == OWN_GAP);

    // The chosen line's mark is cleared as its grant fires.
    always_comb clr = grant_fire ? pick_oh : '0;

    rg_req_capture #(.NCH(NCH)) req_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .line_low   (line_low),
        .clr        (clr),
        .pend       (pend)
    );

    rg_prio_pick #(.NCH(NCH), .CH_W(CH_W)) pick_i (
        .req      (pend),
        .any      (any_pend),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    rg_boundary_gate gate_i (
        .phase_t4    (phase_t4),
        .phase_t1    (phase_t1),
        .lock_active (lock_active),
        .inta_first  (inta_first),
        .split_word  (split_word),
        .gate_open   (gate_open)
    );

    rg_own_fsm #(.NCH(NCH), .CH_W(CH_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_low   (line_low),
        .any_pend   (any_pend),
        .gate_open  (gate_open),
        .pick_idx   (pick_idx),
        .state      (state),
        .grant_fire (grant_fire),
        .rg_drive   (rg_drive),
        .bus_float  (bus_float)
    );
endmodule

// File: rtl/busown_arbiter_chk.sv
// Port-level protocol checks for busown_arbiter, attached by bind.
module busown_arbiter_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] rg_drive,
    input logic           bus_float,
    input logic           phase_t4,
    input logic           phase_t1,
    input logic           lock_active,
    input logic           inta_first,
    input logic           split_word
);
    // R5: never more than one line driven at once.
    a_r5_single_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rg_drive));

    // R5: a grant pulse is one clock wide.
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drive != '0) |=> (rg_drive == '0));

    // R6: bus floats in the cycle after the grant pulse.
    a_r6_float_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drive != '0) |=> bus_float);

    // R6: float only ever begins right after a grant pulse.
    a_r6_float_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_float) |-> ($past(rg_drive) != '0));

    // R3: grants start only after a boundary edge.
    a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drive != '0) |-> $past(phase_t4 || phase_t1));

    // R4: grants start only when nothing blocks.
    a_r4_not_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drive != '0) |-> $past(!lock_active && !inta_first && !split_word));

    // R8: the cycle after a release carries neither float nor grant.
    a_r8_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_float) |=> (rg_drive == '0) && !bus_float);

    // R12: host never pulls a line while the bus is floated.
    a_r12_no_drive_floated: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_drive != '0) |-> !bus_float);
endmodule

bind busown_arbiter busown_arbiter_chk #(.NCH(NCH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rg_drive    (rg_drive),
    .bus_float   (bus_float),
    .phase_t4    (phase_t4),
    .phase_t1    (phase_t1),
    .lock_active (lock_active),
    .inta_first  (inta_first),
    .split_word  (split_word)
);

// File: tb/busown_arbiter_tb_top.sv
`timescale 1ns/1ps
module busown_arbiter_tb_top;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] mpull = '0;
    logic [NCH-1:0] rg_in_n;
    logic           phase_t4 = 1'b0, phase_t1 = 1'b0;
    logic           lock_active = 1'b0, inta_first = 1'b0, split_word = 1'b0;
    logic [NCH-1:0] rg_drive;
    logic           bus_float;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Open-drain line: low when host or master pulls it.
    assign rg_in_n = ~(rg_drive | mpull);

    busown_arbiter #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .rg_in_n(rg_in_n),
        .phase_t4(phase_t4), .phase_t1(phase_t1),
        .lock_active(lock_active), .inta_first(inta_first), .split_word(split_word),
        .rg_drive(rg_drive), .bus_float(bus_float)
    );

    // Requirement-level reference: 0 host, 1 grant, 2 master, 3 gap.
    int             m_st = 0;
    int             m_own = 0;
    logic [NCH-1:0] m_pend = '0;

    function automatic logic [NCH-1:0] exp_drive();
        logic [NCH-1:0] d = '0;
        if (m_st == 1) d[m_own] = 1'b1;
        return d;
    endfunction

    function automatic logic exp_float();
        return m_st == 2;
    endfunction

    function automatic int lowest(input logic [NCH-1:0] v);
        for (int c = 0; c < NCH; c++) if (v[c]) return c;
        return 0;
    endfunction

    // Advance the reference model one clock.
    always @(posedge clk) begin
        logic [NCH-1:0] low;
        logic [NCH-1:0] np;
        low = exp_drive() | mpull;
        if (!rst_n) begin
            m_st <= 0; m_own <= 0; m_pend <= '0;
        end else begin
            np = m_pend;
            if (m_st == 0 || m_st == 3) np = np | low;
            case (m_st)
                0: if (m_pend != '0 && (phase_t4 || phase_t1) &&
                       !lock_active && !inta_first && !split_word) begin
                       m_st <= 1; m_own <= lowest(m_pend);
                       np[lowest(m_pend)] = 1'b0;
                   end
                1: m_st <= 2;
                2: if (low[m_own]) m_st <= 3;
                default: m_st <= 0;
            endcase
            m_pend <= np;
        end
    end

    task automatic check(input logic [NCH-1:0] ed, input logic ef, input string tag);
        checks++;
        if (rg_drive !== ed || bus_float !== ef) begin
            errors++;
            $display("FAIL %s: drive=%b float=%b expected drive=%b float=%b",
                     tag, rg_drive, bus_float, ed, ef);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One-clock low pulse from masters; returns at the negedge after the sampling edge.
    task automatic pulse(input logic [NCH-1:0] m);
        mpull = m;
        step();
        mpull = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
    end

    initial begin
        repeat (3) step();
        check('0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        step();
        check('0, 1'b0, "R1 after reset");

        // R2/R3: request held while no boundary, then granted.
        pulse(2'b01);
        for (int i = 0; i < 3; i++) begin check('0, 1'b0, "R3 no boundary"); step(); end
        phase_t4 = 1'b1;
        step();
        check(2'b01, 1'b0, "R2 grant pulse line0");
        phase_t4 = 1'b0;
        step();
        check('0, 1'b1, "R5 R6 pulse ends, float");

        // R11: other line pulses during ownership are ignored.
        pulse(2'b10);
        check('0, 1'b1, "R11 no release from other line");
        pulse(2'b01);
        check('0, 1'b0, "R7 release");
        phase_t1 = 1'b1;
        step();
        check('0, 1'b0, "R8 dead cycle");
        step();
        check('0, 1'b0, "R11 ignored pulse not marked");

        // R4: each blocking flag withholds the grant.
        lock_active = 1'b1;
        pulse(2'b10);
        for (int i = 0; i < 3; i++) begin check('0, 1'b0, "R4 lock"); step(); end
        lock_active = 1'b0; inta_first = 1'b1;
        for (int i = 0; i < 2; i++) begin step(); check('0, 1'b0, "R4 inta"); end
        inta_first = 1'b0; split_word = 1'b1;
        for (int i = 0; i < 2; i++) begin step(); check('0, 1'b0, "R4 split"); end
        split_word = 1'b0;
        step();
        check(2'b10, 1'b0, "R4 grant after unblock");
        step();
        check('0, 1'b1, "R6 float line1");
        pulse(2'b10);
        check('0, 1'b0, "R7 release line1");

        // R9/R10: simultaneous requests.
        phase_t1 = 1'b0;
        step(); step();
        pulse(2'b11);
        phase_t1 = 1'b1;
        step();
        check(2'b01, 1'b0, "R9 line0 first");
        step();
        check('0, 1'b1, "R6 float");
        pulse(2'b01);
        check('0, 1'b0, "R7 release");
        step();
        check('0, 1'b0, "R8 gap");
        step();
        check(2'b10, 1'b0, "R10 held request granted");
        step();
        pulse(2'b10);
        check('0, 1'b0, "R7 release line1");

        // Random phase against the model (R2-R12).
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < 3000; n++) begin
            phase_t4    = ($urandom % 3) == 0;
            phase_t1    = ($urandom % 3) == 0;
            lock_active = ($urandom % 6) == 0;
            inta_first  = ($urandom % 8) == 0;
            split_word  = ($urandom % 8) == 0;
            mpull[0]    = ($urandom % 5) == 0;
            mpull[1]    = ($urandom % 5) == 0;
            step();
            check(exp_drive(), exp_float(), "R12 random vs model");
        end
        mpull = '0;
        summary();
    end
endmodule